// File: doc/BRIEF.md
# Preload-then-Playback Pattern Buffer

This block sits between a host write stream and a set of digital output pins. A host pushes a complete output pattern, one word per step, over a valid/ready stream. The block stores every word in on-chip memory. Playback cannot begin until the whole pattern is resident, so the output never stalls partway through for lack of data. A start command that arrives while words are still coming in is remembered and acted on once the last word has landed.

During playback the stored words are read back in the order they were written. One word goes to a registered output on each tick of an external clock-enable, which comes from a cycle divider. For example, dividing a 60 MHz fabric clock by 10 gives one step every 10 cycles. After the final step the block returns to idle and emits a one-cycle completion pulse. The host waits for this pulse before it tears down its transfer. The output keeps showing the last word until the next playback begins.

The memory depth is a parameter. Its default of 6144 words covers patterns of at least 6003 steps. A requested length larger than the depth is handled as follows: the excess words are still drained from the stream, but they are discarded, and an overflow flag is raised.

Top module: `pattern_playback`

## Requirements
- R1: After reset, `pat_o` is 0 and `busy_o`, `done_o`, `wr_ready_o` and `overflow_o` are all 0.
- R2: `wr_ready_o` is high only while a load is in progress. A load begins on the clock edge at which the block is idle, `wr_valid_i` is high and `len_i` is nonzero. `len_i` is captured on that edge. When `len_i` is 0, the request is ignored and `wr_ready_o` stays low.
- R3: A `start_i` pulse seen during a load is held. Playback begins only after the last of the `len_i` words has been accepted: two edges after that final accept, whether the start came earlier or on the same edge as the final word.
- R4: In playback, on each edge where `tick_i` is high, `pat_o` takes the next stored word, starting from the first word written. `tick_i` has no effect outside playback.
- R5: `done_o` is a one-cycle pulse. It rises on the same edge on which the final word appears on `pat_o`. `busy_o` falls on that same edge.
- R6: After playback ends, `pat_o` holds the final word until the first tick of the next playback.
- R7: If `len_i` exceeds the depth, the first depth words are stored and the remaining words are accepted and discarded. `overflow_o` rises on the edge that accepts the first excess word and stays high until the next load begins. Playback then covers exactly depth steps.
- R8: After a completed playback, a new load writes from address 0. The next playback therefore starts with the new pattern's first word.
- R9: `busy_o` is high from the edge on which playback begins until the edge that outputs the final word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Pattern word on `wr_data_i` is valid |
| wr_data_i | input | DATA_W | Pattern word |
| wr_ready_o | output | 1 | Block accepts a word this cycle |
| len_i | input | LEN_W | Pattern length in steps, captured at load start |
| start_i | input | 1 | Playback request pulse |
| tick_i | input | 1 | Step enable from the cycle divider |
| pat_o | output | DATA_W | Registered pattern word for the pins |
| busy_o | output | 1 | Playback in progress |
| done_o | output | 1 | One-cycle completion pulse |
| overflow_o | output | 1 | Words beyond the depth were discarded |

## Verification
Two situations coincide in a single cycle, and both are provoked directly. In the first, the start request arrives on the same edge that accepts the final pattern word. The bench presents `start_i` together with the last stream word and expects playback to begin two edges later, exactly as it would for a start seen earlier in the load. In the second, a tick arrives in the cycle in which playback is still waiting, or has already finished. The bench drives ticks in the ready state and after completion, and expects `pat_o` to stay frozen. Every playback is stepped by either random or divided ticks, and each output word is compared against a bench-held copy of the pattern.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_READY = 2'd2,
    ST_PLAY  = 2'd3
  } pb_state_e;
endpackage

// File: rtl/pb_mem.sv
module pb_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6144,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // output register doubles as the pin register; holds between reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end

  a_r7_wr_in_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_addr_i) < DEPTH));
  a_r4_rd_in_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> (int'(rd_addr_i) < DEPTH));
endmodule

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import pb_pkg::*;
#(
  parameter int DEPTH = 6144,
  parameter int LEN_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              wr_ready_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overflow_o
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);

  pb_state_e        state_q;
  logic [LEN_W-1:0] cnt_q, req_q, plen_q;
  logic             pend_q, ovf_q, done_q;
  logic             accept, in_range, last_wr, last_rd;

  assign wr_ready_o = (state_q == ST_LOAD);
  assign accept     = wr_valid_i & wr_ready_o;
  assign in_range   = (cnt_q < DEPTH_L);
  assign wr_en_o    = accept & in_range;
  assign wr_addr_o  = cnt_q[ADDR_W-1:0];
  assign rd_en_o    = (state_q == ST_PLAY) & tick_i;
  assign rd_addr_o  = cnt_q[ADDR_W-1:0];
  assign last_wr    = (cnt_q == req_q - ONE_L);
  assign last_rd    = (cnt_q == plen_q - ONE_L);
  assign busy_o     = (state_q == ST_PLAY);
  assign done_o     = done_q;
  assign overflow_o = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      req_q   <= '0;
      plen_q  <= '0;
      pend_q  <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (wr_valid_i && (len_i != '0)) begin
            req_q   <= len_i;
            plen_q  <= (len_i > DEPTH_L) ? DEPTH_L : len_i;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            ovf_q   <= 1'b0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (start_i) pend_q <= 1'b1;
          if (accept) begin
            if (!in_range) ovf_q <= 1'b1;
            if (last_wr) begin
              cnt_q   <= '0;
              state_q <= ST_READY;
            end else begin
              cnt_q <= cnt_q + ONE_L;
            end
          end
        end
        ST_READY: begin
          if (start_i || pend_q) begin
            pend_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_PLAY;
          end
        end
        ST_PLAY: begin
          if (tick_i) begin
            if (last_rd) begin
              done_q  <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + ONE_L;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_no_play_from_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) |=> (state_q != ST_PLAY));
  a_r4_rd_below_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (cnt_q < plen_q));
  a_r7_plen_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (plen_q <= DEPTH_L));
endmodule

// File: rtl/pattern_playback.sv
module pattern_playback #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6144,
  parameter int LEN_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              start_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] pat_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overflow_o
);
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  pb_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .len_i      (len_i),
    .start_i    (start_i),
    .tick_i     (tick_i),
    .wr_ready_o (wr_ready_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .rd_en_o    (rd_en),
    .rd_addr_o  (rd_addr),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .overflow_o (overflow_o)
  );

  pb_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (pat_o)
  );

  a_r2_no_ready_in_play: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !wr_ready_o);
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r6_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(pat_o));
endmodule

// File: tb/pattern_playback_test.sv
module pattern_playback_test;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 32;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_valid_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              wr_ready_o;
  logic [LEN_W-1:0]  len_i = '0;
  logic              start_i = 1'b0;
  logic              tick_i = 1'b0;
  logic [DATA_W-1:0] pat_o;
  logic              busy_o, done_o, overflow_o;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;
  logic [DATA_W-1:0] pat [64];

  always #5 clk = ~clk;

  pattern_playback #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .wr_ready_o(wr_ready_o), .len_i(len_i), .start_i(start_i), .tick_i(tick_i),
    .pat_o(pat_o), .busy_o(busy_o), .done_o(done_o), .overflow_o(overflow_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; errs++;
      $display("FAIL watchdog: run hung act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int n);
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) pat[i] = DATA_W'($urandom);
  endtask

  // loads n words; start_i is pulsed alongside word start_at (-1: none)
  task automatic do_load(input int n, input int start_at);
    len_i = LEN_W'(n);
    for (int i = 0; i < n; i++) begin
      if ($urandom % 4 == 0) begin
        wr_valid_i = 1'b0;
        @(negedge clk);
      end
      wr_valid_i = 1'b1;
      wr_data_i  = pat[i];
      while (!wr_ready_o) @(negedge clk);
      start_i = (i == start_at);
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b0, "R3 no playback during load", busy_o, 0);
      chk(overflow_o == (i >= DEPTH), "R7 overflow flag", overflow_o, (i >= DEPTH));
    end
    wr_valid_i = 1'b0;
  endtask

  // div = 0: random ticks, else a tick every div cycles
  task automatic do_play(input int n, input bit started, input int div);
    logic [DATA_W-1:0] prev;
    int idx, k;
    prev = pat_o;
    if (started) begin
      chk(busy_o == 1'b0, "R3 one cycle in ready", busy_o, 0);
      @(negedge clk);
    end else begin
      for (int j = 0; j < 2; j++) begin
        tick_i = 1'b1;
        @(negedge clk);
        chk(pat_o == prev && !busy_o, "R4 tick ignored before start", pat_o, prev);
      end
      tick_i  = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    chk(pat_o == prev, "R6 holds until first tick", pat_o, prev);
    idx = 0; k = 0;
    while (idx < n) begin
      tick_i = (div == 0) ? ($urandom % 3 == 0) : (k % div == div - 1);
      k++;
      @(negedge clk);
      if (tick_i) begin
        chk(pat_o == pat[idx], "R4 word order", pat_o, pat[idx]);
        chk(done_o == (idx == n - 1), "R5 done timing", done_o, (idx == n - 1));
        chk(busy_o == (idx != n - 1), "R9 busy span", busy_o, (idx != n - 1));
        idx++;
      end else begin
        chk(!done_o && busy_o, "R5 no done between ticks", {busy_o, done_o}, 2'b10);
      end
    end
    tick_i = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R5 done single cycle", done_o, 0);
    for (int j = 0; j < 3; j++) begin
      tick_i = 1'(j);
      @(negedge clk);
      chk(pat_o == pat[n - 1] && !busy_o, "R6 hold after done", pat_o, pat[n - 1]);
    end
    tick_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(pat_o == '0 && !busy_o && !done_o && !wr_ready_o && !overflow_o,
        "R1 reset state", {pat_o, busy_o, done_o, wr_ready_o, overflow_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: zero length never opens a load
    len_i = '0; wr_valid_i = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(wr_ready_o == 1'b0, "R2 zero length ignored", wr_ready_o, 0);
    end
    wr_valid_i = 1'b0;

    // basic load then start
    fill(12); do_load(12, -1);
    chk(wr_ready_o == 1'b0, "R2 ready low after load", wr_ready_o, 0);
    do_play(12, 1'b0, 0);

    // start mid-load, divided ticks
    fill(20); do_load(20, 7); do_play(20, 1'b1, 5);

    // start on the same edge as the last word (R3 corner)
    fill(9); do_load(9, 8); do_play(9, 1'b1, 0);

    // overflow: length beyond depth
    fill(DEPTH + 5); do_load(DEPTH + 5, -1);
    chk(overflow_o == 1'b1, "R7 overflow held", overflow_o, 1);
    do_play(DEPTH, 1'b0, 2);
    chk(overflow_o == 1'b1, "R7 overflow kept to next load", overflow_o, 1);

    // exact depth after overflow: flag clears, new data from address 0 (R8)
    fill(DEPTH); do_load(DEPTH, 3);
    chk(overflow_o == 1'b0, "R7 overflow cleared", overflow_o, 0);
    do_play(DEPTH, 1'b1, 0);

    // single-step pattern
    fill(1); do_load(1, 0); do_play(1, 1'b1, 3);

    // random lengths and start positions
    for (int r = 0; r < 6; r++) begin
      int n, s;
      n = 1 + int'($urandom % (DEPTH + 4));
      s = ($urandom % 2 == 0) ? -1 : int'($urandom % eff_len(n));
      fill(n);
      do_load(n, s);
      do_play(eff_len(n), s >= 0, int'($urandom % 4));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule